// File: doc/BRIEF.md
# Timer Interrupt Status Flags

This block holds the sticky event flags of a general-purpose timer and combines them into one interrupt request. Hardware events from the counter, the trigger logic, the commutation logic, the break input and each capture/compare channel arrive as single-cycle strobes or levels. Each event sets its flag, and the flag stays set until software clears it.

Software sees the whole flag vector on one output and clears flags by writing a word. A zero in a bit position clears that flag and a one leaves it as it is, so clearing one flag cannot disturb another. Some events are qualified before they set a flag. An update from overflow, software reinitialisation or trigger reinitialisation depends on the update-disable and update-source controls. A trigger depends on the slave controller's gated setting. The break flag cannot be cleared while the break level is still high. An overcapture flag records a capture that arrives while the previous one is still unacknowledged.

Top module: `tmr_irq_status`

## Requirements
- R1: When `rst_n` is low at a clock edge, every bit of `flags` becomes 0 and `irq` is 0.
- R2: The update flag (`flags[0]`) is set after a cycle with `ovf_evt` high only when `rep_zero` is high and `upd_dis` is low in that cycle.
- R3: A cycle with `swgen_evt` or `trgreinit_evt` high sets the update flag only when both `upd_src` and `upd_dis` are low in that cycle.
- R4: The trigger flag (`flags[1]`) is set when `trg_in` goes from 0 to 1 while `gated_mode` is low. When `gated_mode` is high, it is set on any change of `trg_in`. `trg_in` counts as 0 during reset.
- R5: `com_evt` high sets the commutation flag (`flags[2]`).
- R6: The break flag (`flags[3]`) is set in every cycle in which `brk_in` is high. A software clear of it takes effect only in a cycle where `brk_in` is low.
- R7: `cc_evt[c]` sets the channel flag `flags[4+c]`. The overcapture flag `flags[4+NUM_CC+c]` is set when `cc_evt[c]` and `cc_in_mode[c]` are both high while `flags[4+c]` is already 1. It is never set while `cc_in_mode[c]` is low.
- R8: A cycle with `wr_en` high clears every flag whose `wr_data` bit is 0 and leaves every flag whose `wr_data` bit is 1 unchanged. Bit positions follow R2–R7.
- R9: When a flag's set event and a software clear of that flag fall in the same cycle, the flag is 1 afterwards.
- R10: `irq` is high exactly when some bit is 1 in both `flags` and `irq_en`. It follows the registered flags with no extra cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ovf_evt | input | 1 | Counter overflow/underflow strobe |
| rep_zero | input | 1 | Repetition count has reached zero |
| swgen_evt | input | 1 | Software-forced counter reinitialisation strobe |
| trgreinit_evt | input | 1 | Trigger-caused counter reinitialisation strobe |
| upd_dis | input | 1 | Update-disable control bit |
| upd_src | input | 1 | Update-source select (1 = overflow only) |
| trg_in | input | 1 | Trigger input level, already synchronised |
| gated_mode | input | 1 | Slave controller is in gated mode |
| com_evt | input | 1 | Commutation event strobe (control bits updated) |
| brk_in | input | 1 | Break input level, active high |
| cc_evt | input | NUM_CC | Per-channel compare match or capture strobe |
| cc_in_mode | input | NUM_CC | Per-channel input capture mode |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 4+2*NUM_CC | Write word; 0 bits clear flags |
| irq_en | input | 4+2*NUM_CC | Per-flag interrupt enable |
| flags | output | 4+2*NUM_CC | Flag vector |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume the event strobes last one cycle and do not rely on anything else. They assume that `trg_in` comes from a clock-synchronous source. They also assume that `wr_data` is only meaningful while `wr_en` is high. The random phase changes inputs only on the falling clock edge. It keeps `brk_in` low most of the time so that clears of the break flag are tried both while it is held and after it is released. It raises `wr_en` with random words so that sets and clears often land in the same cycle. Directed cases first walk through each qualifying control bit and each trigger mode.

// File: rtl/tmr_irq_pkg.sv
// Package: shared bit positions of the flag vector and a width helper.
// Assumes channel flags sit above the four fixed event flags.
package tmr_irq_pkg;
    localparam int IDX_UPD = 0;
    localparam int IDX_TRG = 1;
    localparam int IDX_COM = 2;
    localparam int IDX_BRK = 3;
    localparam int IDX_CC  = 4;

    // Width of the flag vector for a channel count.
    function automatic int flag_width(input int n_cc);
        return IDX_CC + 2 * n_cc;
    endfunction
endpackage

// File: rtl/tmr_upd_qual.sv
// Qualifies update sources and trigger edges into single-cycle set pulses.
// Assumes trg_in is synchronous to clk; its previous value is held here.
module tmr_upd_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf_evt,
    input  logic rep_zero,
    input  logic swgen_evt,
    input  logic trgreinit_evt,
    input  logic upd_dis,
    input  logic upd_src,
    input  logic trg_in,
    input  logic gated_mode,
    output logic upd_set,
    output logic trg_set
);
    logic trg_q;
    logic ovf_ok;
    logic reinit_ok;
    logic rise;
    logic fall;

    // Remember last trigger level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) trg_q <= 1'b0;
        else        trg_q <= trg_in;
    end

    // Update qualification: overflow path and reinitialisation path.
    always_comb begin
        ovf_ok    = ovf_evt & rep_zero;
        reinit_ok = (swgen_evt | trgreinit_evt) & ~upd_src;
        upd_set   = (ovf_ok | reinit_ok) & ~upd_dis;
    end

    // Trigger edge selection by slave mode.
    always_comb begin
        rise    = trg_in & ~trg_q;
        fall    = ~trg_in & trg_q;
        trg_set = gated_mode ? (rise | fall) : rise;
    end

    // R3
    src_blocks_reinit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_src && !ovf_evt) |-> !upd_set);

    // R4
    nongated_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gated_mode && !trg_in) |-> !trg_set);
endmodule

// File: rtl/tmr_flag_cell.sv
// One sticky flag: hardware set beats software clear; clear may be held off.
// Assumes clr_i is already decoded from the write strobe and data bit.
module tmr_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic hold_i,
    output logic q
);
    // Flag state update with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n)                q <= 1'b0;
        else if (set_i)            q <= 1'b1;
        else if (clr_i && !hold_i) q <= 1'b0;
    end

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> (q == $past(q)));

    // R6
    guarded_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && q) |=> q);
endmodule

// File: rtl/tmr_cc_qual.sv
// Per-channel set pulses for the event flag and the overcapture flag.
// Assumes cur_flag is the registered channel flag before this cycle's update.
module tmr_cc_qual (
    input  logic cc_evt,
    input  logic cc_in_mode,
    input  logic cur_flag,
    output logic evt_set,
    output logic ovr_set
);
    // Overcapture only when a capture lands on a pending flag.
    always_comb begin
        evt_set = cc_evt;
        ovr_set = cc_evt & cc_in_mode & cur_flag;
    end
endmodule

// File: rtl/tmr_irq_status.sv
// Timer interrupt status: sticky flags, write-zero-to-clear, combined irq.
// Assumes strobes are one cycle wide and all inputs are clk-synchronous.
module tmr_irq_status
    import tmr_irq_pkg::*;
#(
    parameter  int NUM_CC = 2,
    localparam int FW     = flag_width(NUM_CC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ovf_evt,
    input  logic              rep_zero,
    input  logic              swgen_evt,
    input  logic              trgreinit_evt,
    input  logic              upd_dis,
    input  logic              upd_src,
    input  logic              trg_in,
    input  logic              gated_mode,
    input  logic              com_evt,
    input  logic              brk_in,
    input  logic [NUM_CC-1:0] cc_evt,
    input  logic [NUM_CC-1:0] cc_in_mode,
    input  logic              wr_en,
    input  logic [FW-1:0]     wr_data,
    input  logic [FW-1:0]     irq_en,
    output logic [FW-1:0]     flags,
    output logic              irq
);
    localparam int IDX_OVR = IDX_CC + NUM_CC;

    logic [FW-1:0] set_v;
    logic [FW-1:0] hold_v;
    logic [FW-1:0] clr_v;
    logic          upd_set;
    logic          trg_set;

    tmr_upd_qual u_qual (
        .clk           (clk),
        .rst_n         (rst_n),
        .ovf_evt       (ovf_evt),
        .rep_zero      (rep_zero),
        .swgen_evt     (swgen_evt),
        .trgreinit_evt (trgreinit_evt),
        .upd_dis       (upd_dis),
        .upd_src       (upd_src),
        .trg_in        (trg_in),
        .gated_mode    (gated_mode),
        .upd_set       (upd_set),
        .trg_set       (trg_set)
    );

    // Fixed event set pulses and break clear guard.
    always_comb begin
        set_v[IDX_UPD]  = upd_set;
        set_v[IDX_TRG]  = trg_set;
        set_v[IDX_COM]  = com_evt;
        set_v[IDX_BRK]  = brk_in;
        hold_v          = '0;
        hold_v[IDX_BRK] = brk_in;
    end

    // Software clear request per bit: written zero.
    always_comb begin
        clr_v = {FW{wr_en}} & ~wr_data;
    end

    for (genvar c = 0; c < NUM_CC; c++) begin : g_cc
        tmr_cc_qual u_cc (
            .cc_evt     (cc_evt[c]),
            .cc_in_mode (cc_in_mode[c]),
            .cur_flag   (flags[IDX_CC + c]),
            .evt_set    (set_v[IDX_CC + c]),
            .ovr_set    (set_v[IDX_OVR + c])
        );

        // R7
        out_mode_no_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cc_evt[c] && !cc_in_mode[c] && !flags[IDX_OVR + c] && (!wr_en || wr_data[IDX_OVR + c]))
            |=> !flags[IDX_OVR + c]);
    end

    for (genvar i = 0; i < FW; i++) begin : g_flag
        tmr_flag_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_v[i]),
            .clr_i  (clr_v[i]),
            .hold_i (hold_v[i]),
            .q      (flags[i])
        );
    end

    // Combined interrupt request.
    always_comb begin
        irq = |(flags & irq_en);
    end

    // R2
    dis_blocks_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_dis && !flags[IDX_UPD] && (!wr_en || wr_data[IDX_UPD])) |=> !flags[IDX_UPD]);

    // R6
    brk_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_in |=> flags[IDX_BRK]);

    // R5
    com_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        com_evt |=> flags[IDX_COM]);

    // R10
    no_enable_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == '0) |-> !irq);
endmodule

// File: tb/tmr_irq_status_tb_top.sv
`timescale 1ns/1ps
module tmr_irq_status_tb_top;
    localparam int NCC = 2;
    localparam int W   = 4 + 2 * NCC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ovf_evt = 0, rep_zero = 0, swgen_evt = 0, trgreinit_evt = 0;
    logic upd_dis = 0, upd_src = 0, trg_in = 0, gated_mode = 0;
    logic com_evt = 0, brk_in = 0, wr_en = 0;
    logic [NCC-1:0] cc_evt = '0, cc_in_mode = '0;
    logic [W-1:0] wr_data = '0, irq_en = '0;
    logic [W-1:0] flags;
    logic irq;

    int checks = 0;
    int errs = 0;
    bit done = 0;
    logic [W-1:0] exp_f = '0;
    logic tprev_m = 0;

    always #2.5 clk = ~clk;

    tmr_irq_status #(.NUM_CC(NCC)) dut_i (
        .clk(clk), .rst_n(rst_n), .ovf_evt(ovf_evt), .rep_zero(rep_zero),
        .swgen_evt(swgen_evt), .trgreinit_evt(trgreinit_evt), .upd_dis(upd_dis),
        .upd_src(upd_src), .trg_in(trg_in), .gated_mode(gated_mode),
        .com_evt(com_evt), .brk_in(brk_in), .cc_evt(cc_evt), .cc_in_mode(cc_in_mode),
        .wr_en(wr_en), .wr_data(wr_data), .irq_en(irq_en), .flags(flags), .irq(irq)
    );

    // Next flag vector from the requirements and the current inputs.
    function automatic logic [W-1:0] model_next(input logic [W-1:0] cur);
        logic [W-1:0] s, clr;
        s = '0;
        s[0] = (ovf_evt & rep_zero & ~upd_dis) |
               ((swgen_evt | trgreinit_evt) & ~upd_src & ~upd_dis);
        s[1] = gated_mode ? (trg_in ^ tprev_m) : (trg_in & ~tprev_m);
        s[2] = com_evt;
        s[3] = brk_in;
        for (int c = 0; c < NCC; c++) begin
            s[4 + c]       = cc_evt[c];
            s[4 + NCC + c] = cc_evt[c] & cc_in_mode[c] & cur[4 + c];
        end
        clr = wr_en ? ~wr_data : '0;
        if (brk_in) clr[3] = 1'b0;
        return (cur & ~clr) | s;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock with the present inputs; compare flags and irq afterwards.
    task automatic tick(input string tag);
        exp_f   = model_next(exp_f);
        tprev_m = trg_in;
        @(posedge clk);
        @(negedge clk);
        chk({tag, " flags"}, 32'(flags), 32'(exp_f));
        chk("R10 irq", 32'(irq), 32'(|(exp_f & irq_en)));
    endtask

    task automatic wr(input logic [W-1:0] d, input string tag);
        wr_en = 1; wr_data = d;
        tick(tag);
        wr_en = 0; wr_data = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errs++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1 reset flags", 32'(flags), 0);
        chk("R1 reset irq", 32'(irq), 0);
        rst_n = 1;

        // R2 overflow qualification
        ovf_evt = 1; rep_zero = 0; tick("R2 rep nonzero");
        chk("R2 no update", 32'(flags[0]), 0);
        rep_zero = 1; upd_dis = 1; tick("R2 disabled");
        chk("R2 disabled no update", 32'(flags[0]), 0);
        upd_dis = 0; tick("R2 qualified");
        chk("R2 update set", 32'(flags[0]), 1);
        ovf_evt = 0; rep_zero = 0;
        wr(8'hFE, "R8 clear update");
        chk("R8 update cleared", 32'(flags[0]), 0);

        // R3 reinitialisation sources
        swgen_evt = 1; upd_src = 1; tick("R3 src masks sw");
        chk("R3 sw masked", 32'(flags[0]), 0);
        swgen_evt = 0; trgreinit_evt = 1; upd_src = 0; upd_dis = 1; tick("R3 dis masks trg");
        chk("R3 trg masked", 32'(flags[0]), 0);
        upd_dis = 0; tick("R3 trg reinit");
        chk("R3 trg reinit sets", 32'(flags[0]), 1);
        trgreinit_evt = 0;
        wr('0, "R8 clear all");

        // R4 trigger edges
        trg_in = 1; tick("R4 rise nongated");
        chk("R4 rise sets", 32'(flags[1]), 1);
        wr('0, "R8 clear trg");
        trg_in = 0; tick("R4 fall nongated");
        chk("R4 fall ignored", 32'(flags[1]), 0);
        gated_mode = 1; trg_in = 1; tick("R4 gated rise");
        wr('0, "R8 clear trg");
        trg_in = 0; tick("R4 gated fall");
        chk("R4 gated fall sets", 32'(flags[1]), 1);
        gated_mode = 0;
        wr('0, "R8 clear");

        // R5 commutation, R9 set beats clear
        com_evt = 1; tick("R5 com");
        chk("R5 com set", 32'(flags[2]), 1);
        wr_en = 1; wr_data = '0; tick("R9 set vs clear");
        chk("R9 set wins", 32'(flags[2]), 1);
        wr_en = 0; com_evt = 0;
        wr(8'hFF, "R8 write ones");
        chk("R8 ones keep com", 32'(flags[2]), 1);
        wr('0, "R8 clear");

        // R6 break guard
        brk_in = 1; tick("R6 break high");
        wr('0, "R6 clear while high");
        chk("R6 clear refused", 32'(flags[3]), 1);
        brk_in = 0; tick("R6 break low");
        chk("R6 still pending", 32'(flags[3]), 1);
        wr('0, "R6 clear after release");
        chk("R6 cleared", 32'(flags[3]), 0);

        // R7 channel flags and overcapture
        cc_in_mode = 2'b01; cc_evt = 2'b11; tick("R7 first events");
        chk("R7 ch flags", 32'(flags[5:4]), 2'b11);
        chk("R7 no ovr yet", 32'(flags[7:6]), 0);
        tick("R7 second events");
        chk("R7 ovr input only", 32'(flags[7:6]), 2'b01);
        cc_evt = '0;

        // R10 interrupt enable
        irq_en = 8'h40; tick("R10 enabled ovr");
        chk("R10 irq high", 32'(irq), 1);
        irq_en = 8'h08; #0.1;
        chk("R10 irq masked", 32'(irq), 0);
        wr('0, "R8 clear");

        // Random phase
        for (int n = 0; n < 3000; n++) begin
            ovf_evt       = ($urandom_range(0, 3) == 0);
            rep_zero      = $urandom_range(0, 1);
            swgen_evt     = ($urandom_range(0, 7) == 0);
            trgreinit_evt = ($urandom_range(0, 7) == 0);
            upd_dis       = ($urandom_range(0, 3) == 0);
            upd_src       = $urandom_range(0, 1);
            trg_in        = ($urandom_range(0, 2) == 0) ? ~trg_in : trg_in;
            gated_mode    = ($urandom_range(0, 15) == 0) ? ~gated_mode : gated_mode;
            com_evt       = ($urandom_range(0, 7) == 0);
            brk_in        = ($urandom_range(0, 9) == 0);
            cc_evt        = NCC'($urandom);
            cc_in_mode    = NCC'($urandom);
            wr_en         = ($urandom_range(0, 2) == 0);
            wr_data       = W'($urandom);
            irq_en        = W'($urandom);
            tick("R2-model random");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
        $finish;
    end
endmodule